// File: doc/BRIEF.md
# Byte-Exchange Serial Port with Status Flags

This block is a synchronous serial port that works as either bus master or bus slave. Each transfer swaps one data word with the link partner. The default word is 8 bits and goes out most significant bit first. One bit leaves on the outgoing data line while one bit arrives on the incoming line, on the same clock edges. The two shifters, one on each side, behave as one ring, so each side ends up holding the other side's word.

The CPU reaches the block through a small register bus with three addresses: control, status and data.

- **Data address.** A write loads the transmit shifter. A read returns a separate receive buffer.
- **Transmit side.** There is only one buffer, so a new word may be written only when no transfer is in flight.
- **Receive side.** The buffer is double-buffered: each finished word is copied into it and the shifter is free again.
- **Master mode.** The block makes the serial clock from its own clock through a power-of-two divider.
- **Slave mode.** It follows an external serial clock while its select input is low. Clock, select and incoming data are first passed through synchronisers.

Top module: `spi_xcvr`

Register map:

| Address | Register | Fields |
|---|---|---|
| 0 | control | bit0 enable, bit1 master, bit2 clock idle level (CPOL), bit3 clock phase (CPHA), bits 5:4 divider DIV, bit6 interrupt enable |
| 1 | status | bit7 transfer complete, bit6 write collision, bit4 mode fault |
| 2 | data | write loads the shifter, read returns the receive buffer |

## Requirements
- R1: In master mode with enable set, a write to address 2 starts one exchange. MOSI carries the written byte, most significant bit first. The byte sampled from MISO can then be read at address 2.
- R2: In master mode SCK rests at the CPOL level between transfers. A transfer makes exactly 16 SCK edges. Each half period lasts 2^(DIV+1) clock cycles.
- R3: With CPHA=0, the incoming bit is sampled on the leading (first) edge of each SCK pulse and the outgoing bit changes on the trailing edge. With CPHA=1, the outgoing bit changes on the leading edge and the sample is taken on the trailing edge. The exchange is correct in both phases and for both CPOL values.
- R4: Status bit7 sets once the eighth bit has been sampled. The irq output is high while control bit6 is set and status bit7 or bit4 is set.
- R5: A write to address 2 during a transfer sets status bit6. That write leaves the word being sent unchanged and starts nothing.
- R6: Status bits 7 and 6 clear only when a status read is followed by an access to address 2. A status read alone does not clear them.
- R7: If a word completes while the receive buffer still holds an unread word, the old word is kept and the new word is lost. Once the buffer has been read, the next word is stored.
- R8: If the select input is low while master mode is enabled, the following happens:
  - status bit4 sets;
  - control bit1 clears;
  - the block stops driving SCK and MOSI.

  Bit4 clears when a status read is followed by a write to address 0.
- R9: In slave mode the block drives MISO only while its select input is low. It then exchanges a word with an external master: MISO carries the word loaded at address 2, and the word received on MOSI can be read at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_sel | input | 1 | register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | register address |
| bus_wdata | input | DATA_W | write data |
| bus_rdata | output | DATA_W | read data, combinational from bus_addr |
| irq | output | 1 | interrupt request |
| sck_i | input | 1 | serial clock from an external master |
| sck_o | output | 1 | serial clock generated as master |
| sck_oe | output | 1 | enable for driving sck_o |
| mosi_i | input | 1 | incoming data in slave mode |
| mosi_o | output | 1 | outgoing data in master mode |
| mosi_oe | output | 1 | enable for driving mosi_o |
| miso_i | input | 1 | incoming data in master mode |
| miso_o | output | 1 | outgoing data in slave mode |
| miso_oe | output | 1 | enable for driving miso_o |
| ss_n_i | input | 1 | select input, active low |

## Verification
A bit counter or phase register that drifts shows up on the pins within one transfer. Either the SCK edge count or the half-period length at the end of the transfer is wrong, or the partner captures a shifted or rotated word. A flag or buffer-full state that is wrong shows up at the next status or data read, through status bits, irq or the byte that comes back. A failure to honour the select input shows up within three clock cycles of the select edge, through the output enables and the control readback.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

   typedef enum logic [1:0] {
      ADR_CTL = 2'd0,
      ADR_STS = 2'd1,
      ADR_DAT = 2'd2,
      ADR_RSV = 2'd3
   } reg_addr_e;

   // control field positions
   localparam int CTL_EN   = 0;
   localparam int CTL_MST  = 1;
   localparam int CTL_CPOL = 2;
   localparam int CTL_CPHA = 3;
   localparam int CTL_DIV  = 4;
   localparam int CTL_IEN  = 6;

   // status field positions
   localparam int STS_DONE = 7;
   localparam int STS_WCOL = 6;
   localparam int STS_MODF = 4;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int          STAGES = 2,
   parameter int          W      = 1,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("spi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage[i] <= INIT;
      end else begin
         stage[0] <= d;
         for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
   parameter int W     = 8,
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             cpol,
   input  logic [DIV_W-1:0] div,
   output logic             busy,
   output logic             sck,
   output logic             lead,
   output logic             trail
);
   localparam int PW = (1 << DIV_W) + 1;
   localparam int EW = $clog2(2 * W);

   logic [PW-1:0] pre;
   logic [PW-1:0] half;
   logic [EW-1:0] ecnt;
   logic          run;
   logic          ph;
   logic          tick;

   always_comb begin
      half = PW'(1) << ({1'b0, div} + (DIV_W+1)'(1));
   end

   assign tick = run && (pre == half - PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         ph   <= 1'b0;
         pre  <= '0;
         ecnt <= '0;
      end else if (abort) begin
         run <= 1'b0;
         ph  <= 1'b0;
      end else if (start && !run) begin
         run  <= 1'b1;
         ph   <= 1'b0;
         pre  <= '0;
         ecnt <= '0;
      end else if (run) begin
         if (tick) begin
            pre  <= '0;
            ph   <= ~ph;
            ecnt <= ecnt + EW'(1);
            if (ecnt == EW'(2 * W - 1)) run <= 1'b0;
         end else begin
            pre <= pre + PW'(1);
         end
      end
   end

   assign busy  = run;
   assign sck   = cpol ^ ph;
   assign lead  = tick && !ecnt[0];
   assign trail = tick &&  ecnt[0];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ldata,
   input  logic         clear,
   input  logic         cpha,
   input  logic         lead,
   input  logic         trail,
   input  logic         sin,
   output logic         sout,
   output logic         done,
   output logic [W-1:0] rx
);
   localparam int IW = $clog2(W);

   logic [W-1:0]  tx;
   logic [IW-1:0] idx;
   logic [IW-1:0] scnt;
   logic          armed;
   logic          samp;
   logic          shft;

   assign samp = cpha ? trail : lead;
   assign shft = cpha ? lead  : trail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx    <= '0;
         rx    <= '0;
         idx   <= '0;
         scnt  <= '0;
         armed <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= samp && (scnt == IW'(W - 1));
         if (load || clear) begin
            if (load) tx <= ldata;
            idx   <= '0;
            scnt  <= '0;
            armed <= 1'b0;
         end else begin
            if (samp) begin
               rx   <= {rx[W-2:0], sin};
               scnt <= (scnt == IW'(W - 1)) ? '0 : scnt + IW'(1);
            end
            if (shft) begin
               // the first leading edge in phase 1 only starts driving bit W-1
               if (!cpha || armed)
                  idx <= (idx == IW'(W - 1)) ? '0 : idx + IW'(1);
               armed <= 1'b1;
            end
         end
      end
   end

   assign sout = tx[IW'(W - 1) - idx];
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
   import spi_xcvr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              ss_n_i
);
   generate
      if (DATA_W < 8) begin : g_bad_w
         $error("spi_xcvr: DATA_W must be at least 8");
      end
      if (DIV_W < 1 || DIV_W > 2) begin : g_bad_div
         $error("spi_xcvr: DIV_W must be 1 or 2");
      end
   endgenerate

   // control and status state
   logic             c_en, c_mst, c_cpol, c_cpha, c_ien;
   logic [DIV_W-1:0] c_div;
   logic             f_done, f_wcol, f_modf, sts_seen;
   logic [DATA_W-1:0] rxbuf;
   logic             rx_full;

   // synchronised pins: {select, clock, data}
   logic [2:0] pin_raw, pin_s;
   logic       s_ss_n, s_sck, s_mosi, sck_prev;

   assign pin_raw = {ss_n_i, sck_i, mosi_i};

   spi_sync #(.STAGES(SYNC_STAGES), .W(3), .INIT(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
   );
   assign {s_ss_n, s_sck, s_mosi} = pin_s;

   // mode decode
   logic is_mst, is_slv, slv_sel, mfault;
   assign is_mst  = c_en &  c_mst;
   assign is_slv  = c_en & ~c_mst;
   assign slv_sel = is_slv & ~s_ss_n;
   assign mfault  = is_mst & ~s_ss_n;

   // bus decode
   logic acc_dat, wr_dat, rd_dat, rd_sts, wr_ctl;
   assign acc_dat = bus_sel && (bus_addr == ADR_DAT);
   assign wr_dat  = acc_dat &&  bus_wr;
   assign rd_dat  = acc_dat && !bus_wr;
   assign rd_sts  = bus_sel && !bus_wr && (bus_addr == ADR_STS);
   assign wr_ctl  = bus_sel &&  bus_wr && (bus_addr == ADR_CTL);

   // master clock
   logic m_busy, m_sck, m_lead, m_trail, busy, load, start, clear;

   spi_clkgen #(.W(DATA_W), .DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(mfault),
      .cpol(c_cpol), .div(c_div), .busy(m_busy), .sck(m_sck),
      .lead(m_lead), .trail(m_trail)
   );

   // slave edge detect
   logic s_chg, s_lead, s_trail;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= s_sck;
   end
   assign s_chg   = slv_sel && (s_sck != sck_prev);
   assign s_lead  = s_chg && (s_sck != c_cpol);
   assign s_trail = s_chg && (s_sck == c_cpol);

   assign busy  = is_mst ? m_busy : slv_sel;
   assign load  = wr_dat && !busy && c_en;
   assign start = load && is_mst && !mfault;
   assign clear = (is_slv && s_ss_n) || mfault || !c_en;

   // shift engine
   logic              sh_out, sh_done;
   logic [DATA_W-1:0] sh_rx;

   spi_shifter #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .ldata(bus_wdata),
      .clear(clear), .cpha(c_cpha),
      .lead(is_mst ? m_lead : s_lead), .trail(is_mst ? m_trail : s_trail),
      .sin(is_mst ? miso_i : s_mosi),
      .sout(sh_out), .done(sh_done), .rx(sh_rx)
   );

   // control register; a mode fault overrides a simultaneous write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_en   <= 1'b0;
         c_mst  <= 1'b0;
         c_cpol <= 1'b0;
         c_cpha <= 1'b0;
         c_div  <= '0;
         c_ien  <= 1'b0;
      end else begin
         if (wr_ctl) begin
            c_en   <= bus_wdata[CTL_EN];
            c_mst  <= bus_wdata[CTL_MST];
            c_cpol <= bus_wdata[CTL_CPOL];
            c_cpha <= bus_wdata[CTL_CPHA];
            c_div  <= bus_wdata[CTL_DIV +: DIV_W];
            c_ien  <= bus_wdata[CTL_IEN];
         end
         if (mfault) c_mst <= 1'b0;
      end
   end

   // status flags: setting wins over clearing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_done   <= 1'b0;
         f_wcol   <= 1'b0;
         f_modf   <= 1'b0;
         sts_seen <= 1'b0;
      end else begin
         f_done <= sh_done       | (f_done & ~(sts_seen & acc_dat));
         f_wcol <= (wr_dat & busy) | (f_wcol & ~(sts_seen & acc_dat));
         f_modf <= mfault        | (f_modf & ~(sts_seen & wr_ctl));
         if (rd_sts)                  sts_seen <= 1'b1;
         else if (acc_dat || wr_ctl)  sts_seen <= 1'b0;
      end
   end

   // receive buffer: an unread word is kept, a newer one is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxbuf   <= '0;
         rx_full <= 1'b0;
      end else if (sh_done && (!rx_full || rd_dat)) begin
         rxbuf   <= sh_rx;
         rx_full <= 1'b1;
      end else if (rd_dat) begin
         rx_full <= 1'b0;
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (reg_addr_e'(bus_addr))
         ADR_CTL: begin
            bus_rdata[CTL_EN]            = c_en;
            bus_rdata[CTL_MST]           = c_mst;
            bus_rdata[CTL_CPOL]          = c_cpol;
            bus_rdata[CTL_CPHA]          = c_cpha;
            bus_rdata[CTL_DIV +: DIV_W]  = c_div;
            bus_rdata[CTL_IEN]           = c_ien;
         end
         ADR_STS: begin
            bus_rdata[STS_DONE] = f_done;
            bus_rdata[STS_WCOL] = f_wcol;
            bus_rdata[STS_MODF] = f_modf;
         end
         ADR_DAT: bus_rdata = rxbuf;
         default: bus_rdata = '0;
      endcase
   end

   assign irq     = c_ien & (f_done | f_modf);
   assign sck_o   = m_sck;
   assign sck_oe  = is_mst;
   assign mosi_o  = sh_out;
   assign mosi_oe = is_mst;
   assign miso_o  = sh_out;
   assign miso_oe = slv_sel;
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         is_mst,
   input logic         busy,
   input logic         cpol,
   input logic         sck_o,
   input logic         sck_oe,
   input logic         wr_dat,
   input logic         rd_dat,
   input logic         rx_full,
   input logic [W-1:0] rxbuf,
   input logic         mfault,
   input logic         c_mst,
   input logic         f_modf,
   input logic         f_wcol,
   input logic         f_done,
   input logic         sh_done
);
   assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mst && !busy) |-> (sck_o == cpol));

   assert_done_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sh_done |=> f_done);

   assert_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dat && busy) |=> f_wcol);

   assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rd_dat) |=> $stable(rxbuf));

   assert_modf_demote_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mfault |=> (f_modf && !c_mst));

   assert_modf_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_modf) |-> !sck_oe);
endmodule

bind spi_xcvr spi_xcvr_chk #(.W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .is_mst(is_mst), .busy(busy), .cpol(c_cpol),
   .sck_o(sck_o), .sck_oe(sck_oe), .wr_dat(wr_dat), .rd_dat(rd_dat),
   .rx_full(rx_full), .rxbuf(rxbuf), .mfault(mfault), .c_mst(c_mst),
   .f_modf(f_modf), .f_wcol(f_wcol), .f_done(f_done), .sh_done(sh_done)
);

// File: tb/sim_spi_xcvr.sv
module sim_spi_xcvr;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
   logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_xcvr u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
   );

   // ---------------- partner slave model for master-mode tests
   logic [7:0] mdl_tx = 8'h00, mdl_cap = 8'h00;
   logic [2:0] mdl_idx = 3'd0;
   logic       mdl_cpol = 1'b0, mdl_cpha = 1'b0;
   int         mdl_leads = 0, mdl_samps = 0, tog_cnt = 0;
   time        t_prev = 0, t_last = 0;

   assign miso_i = mdl_tx[3'd7 - mdl_idx];

   always @(sck_o) begin
      if (sck_oe) begin
         logic is_lead;
         is_lead = (sck_o != mdl_cpol);
         tog_cnt++;
         t_prev = t_last;
         t_last = $time;
         if (mdl_cpha ? !is_lead : is_lead) begin
            mdl_cap = {mdl_cap[6:0], mosi_o};
            mdl_samps++;
         end else if (!mdl_cpha || mdl_leads > 0) begin
            mdl_idx = mdl_idx + 3'd1;
         end
         if (is_lead) mdl_leads++;
      end
   end

   // ---------------- scoreboard
   logic [7:0] exp_mosi[$];
   logic [7:0] exp_rx[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: each word the partner captures is compared with the next driven byte (R1)
   always @(mdl_samps) begin
      if (mdl_samps == 8) begin
         if (exp_mosi.size() == 0) chk("R1 unexpected word on MOSI", 32'(mdl_cap), 32'hFFFF);
         else                     chk("R1 MOSI word", 32'(mdl_cap), 32'(exp_mosi.pop_front()));
      end
   end

   // ---------------- bus tasks
   task automatic bwr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic mcfg(input logic [7:0] ctl);
      bwr(2'd0, ctl);
      mdl_cpol = ctl[2];
      mdl_cpha = ctl[3];
   endtask

   // driver: start a master exchange and push the MOSI expectation
   task automatic mstart(input logic [7:0] tx, input logic [7:0] partner);
      mdl_tx = partner; mdl_idx = 3'd0; mdl_leads = 0; mdl_samps = 0;
      mdl_cap = 8'h00; tog_cnt = 0;
      exp_mosi.push_back(tx);
      bwr(2'd2, tx);
   endtask

   // wait for completion, then check SCK shape (R2)
   task automatic mwait(input int half, input logic cpol);
      logic [7:0] s;
      s = 8'h00;
      for (int k = 0; k < 500; k++) begin
         brd(2'd1, s);
         if (s[7]) break;
      end
      chk("R4 complete flag set", 32'(s[7]), 32'd1);
      repeat (40) @(negedge clk);
      chk("R2 SCK edge count", 32'(tog_cnt), 32'd16);
      chk("R2 SCK half period", 32'(t_last - t_prev), 32'(half * CLK_PERIOD));
      chk("R2 SCK idle level", 32'(sck_o), 32'(cpol));
   endtask

   task automatic rdchk(input string req);
      logic [7:0] d;
      brd(2'd2, d);
      if (exp_rx.size() == 0) chk(req, 32'(d), 32'hFFFF);
      else                   chk(req, 32'(d), 32'(exp_rx.pop_front()));
   endtask

   // ---------------- watchdog
   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus
   initial begin
      logic [7:0] d;
      logic [7:0] cap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      brd(2'd0, d); chk("R8 control after reset", 32'(d), 32'h00);
      brd(2'd1, d); chk("R4 status after reset", 32'(d), 32'h00);
      chk("R4 irq after reset", 32'(irq), 32'd0);
      chk("R9 MISO not driven after reset", 32'(miso_oe), 32'd0);

      // R1, R2: master CPOL=0 CPHA=0 DIV=0, interrupts on
      mcfg(8'h43);
      chk("R2 SCK idles at CPOL=0", 32'(sck_o), 32'd0);
      exp_rx.push_back(8'h3C);
      mstart(8'hA5, 8'h3C);
      mwait(2, 1'b0);
      chk("R4 irq with complete flag", 32'(irq), 32'd1);
      rdchk("R1 received byte");
      brd(2'd1, d); chk("R6 flags cleared after status then data", 32'(d), 32'h00);
      chk("R4 irq low after clear", 32'(irq), 32'd0);

      // R2: CPOL=1, DIV=1 gives half period of 4 clocks
      mcfg(8'h57);
      chk("R2 SCK idles at CPOL=1", 32'(sck_o), 32'd1);
      exp_rx.push_back(8'h0F);
      mstart(8'hF0, 8'h0F);
      mwait(4, 1'b1);
      rdchk("R1 received byte DIV=1");

      // R3: CPHA=1 with both clock polarities, DIV=0 and DIV=3
      mcfg(8'h4B);
      exp_rx.push_back(8'h7E);
      mstart(8'h81, 8'h7E);
      mwait(2, 1'b0);
      rdchk("R3 CPHA=1 CPOL=0 receive");
      mcfg(8'h7F);
      exp_rx.push_back(8'hC3);
      mstart(8'h5A, 8'hC3);
      mwait(16, 1'b1);
      rdchk("R3 CPHA=1 CPOL=1 receive");

      // R5, R6: write collision during a transfer
      mcfg(8'h43);
      exp_rx.push_back(8'h69);
      mstart(8'h96, 8'h69);
      repeat (4) @(negedge clk);
      bwr(2'd2, 8'hFF);
      mwait(2, 1'b0);
      brd(2'd1, d); chk("R5 collision and complete flags", 32'(d), 32'hC0);
      brd(2'd1, d); chk("R6 status read alone keeps flags", 32'(d), 32'hC0);
      rdchk("R5 receive unaffected by collision");
      brd(2'd1, d); chk("R6 flags cleared", 32'(d), 32'h00);

      // R7: overrun keeps the older byte
      exp_rx.push_back(8'h11);
      mstart(8'h01, 8'h11);
      mwait(2, 1'b0);
      mstart(8'h02, 8'h22);
      mwait(2, 1'b0);
      rdchk("R7 older byte kept on overrun");
      exp_rx.push_back(8'h33);
      mstart(8'h03, 8'h33);
      mwait(2, 1'b0);
      rdchk("R7 buffer accepts after read");

      // R8: mode fault
      brd(2'd1, d);
      bwr(2'd2, 8'h00);
      brd(2'd1, d); chk("R8 status clean before fault", 32'(d), 32'h00);
      ss_n_i = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8 SCK released", 32'(sck_oe), 32'd0);
      chk("R8 MOSI released", 32'(mosi_oe), 32'd0);
      chk("R8 irq on mode fault", 32'(irq), 32'd1);
      brd(2'd1, d); chk("R8 mode fault flag", 32'(d), 32'h10);
      brd(2'd0, d); chk("R8 master bit cleared", 32'(d), 32'h41);
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);
      brd(2'd1, d);
      bwr(2'd0, 8'h43);
      brd(2'd1, d); chk("R8 fault cleared by status then control", 32'(d), 32'h00);

      // R9: slave exchange, CPOL=0 CPHA=0
      mcfg(8'h41);
      bwr(2'd2, 8'hB4);
      repeat (4) @(negedge clk);
      chk("R9 MISO idle while deselected", 32'(miso_oe), 32'd0);
      ss_n_i = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 MISO driven while selected", 32'(miso_oe), 32'd1);
      cap = 8'h00;
      for (int i = 0; i < 8; i++) begin
         mosi_i = 8'h4D >> (7 - i);
         repeat (8) @(negedge clk);
         sck_i = 1'b1;
         cap = {cap[6:0], miso_o};
         repeat (8) @(negedge clk);
         sck_i = 1'b0;
      end
      repeat (8) @(negedge clk);
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 slave word on MISO", 32'(cap), 32'hB4);
      brd(2'd1, d); chk("R9 slave complete flag", 32'(d), 32'h80);
      brd(2'd2, d); chk("R9 slave received byte", 32'(d), 32'h4D);
      chk("R9 MISO released after deselect", 32'(miso_oe), 32'd0);

      chk("R1 all MOSI words seen", 32'(exp_mosi.size()), 32'd0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule